// File: doc/BRIEF.md
# Update-Controlled Timer Time-Base

This block is the counting core of a general-purpose timer. A 16-bit counter climbs from zero to an active reload value. It advances once per divided clock tick, where the divider is a power of two set by a 4-bit code. When the counter holds the reload value and a tick arrives, it wraps to zero and the block raises an update event. At that event the shadow copies of the divider code and, optionally, of the reload value are refreshed from the values software last wrote. Software can also request an update on demand, suppress updates altogether, limit which causes may set the sticky update flag, and make the counter stop after one period.

Configuration arrives over a single-cycle register write port: write enable, a 3-bit address and 16 bits of data. No back-pressure applies, and every write is accepted in the cycle it is presented. The outputs are plain control and status pins: a one-clock update pulse, the sticky update flag, the masked interrupt line, the live counter value and the running state.

Register map (address: contents):
- 0, control: bit 0 run, bit 1 update suppress, bit 2 overflow-only flag source, bit 3 single-period mode, bit 4 buffered reload.
- 1, event: writing bit 0 as 1 requests an update.
- 2, flag: writing bit 0 as 0 clears the flag, and writing 1 has no effect.
- 3, divider code: bits 3:0.
- 4, reload value: 16 bits.
- 5, interrupt enable: bit 0.

Top module: `tick_timebase`

## Requirements
- R1: After reset the counter is 0, running_o, upd_pulse_o, upd_flag_o and irq_o are all 0, and the active reload value is 0xFFFF.
- R2: While running with divider code N and active reload value L, upd_pulse_o is high for one clock every (L+1)*2^N clocks. The counter wraps from L to 0 on the tick that raises it.
- R3: Writing the divider code (address 3) does not change the counting rate until the next update event. From that event on, the counter advances once every 2^code clocks.
- R4: Writing 1 to bit 0 of address 1 raises upd_pulse_o in the following cycle. The clock edge that ends that pulse sets the counter and the divider to 0 and loads the shadow registers.
- R5: While control bit 1 is set, neither overflow nor the event write produces a pulse or sets the flag, and the divider code in use is kept. The counter still wraps at the reload value, and an event write does not clear it.
- R6: With control bit 2 clear, both overflow and event writes set upd_flag_o. With control bit 2 set, only overflow sets it.
- R7: With control bit 3 set, running_o drops at the edge that ends an update pulse, and the counter then stays at 0.
- R8: With control bit 4 set, a reload write takes effect at the next update event. With control bit 4 clear, it takes effect at the next clock edge.
- R9: upd_flag_o stays set until address 2 is written with bit 0 equal to 0. Writing 1 there leaves it set, and a new update event in the same cycle as a clear wins over the clear.
- R10: irq_o is upd_flag_o gated by bit 0 of address 5. The enable bit never alters the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| upd_pulse_o | output | 1 | One-clock update event |
| upd_flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Flag masked by interrupt enable |
| count_o | output | 16 | Current counter value |
| running_o | output | 1 | Counter running state |

## Verification
A write is captured at the clock edge where it is presented. A pulse caused by an event write is therefore visible in the cycle right after that edge. The counter, flag and running state reflect the event one edge later still. The bench drives on falling edges and samples on falling edges, placing each check at the falling edge where these counts say the result must already be present. Periods are measured as the number of falling edges between two pulse samples, so the first, possibly partial, period after a configuration change is never compared against (L+1)*2^N.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVENT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd2;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd3;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd4;
  localparam logic [ADDR_W-1:0] A_IEN    = 3'd5;

  localparam int unsigned CTRL_W = 5;

  // packed so that run lands on bit 0 of the control word
  typedef struct packed {
    logic rpre;      // bit 4: buffered reload
    logic oneshot;   // bit 3: stop after one period
    logic ovf_only;  // bit 2: only overflow sets the flag
    logic udis;      // bit 1: suppress update events
    logic run;       // bit 0: counter enable
  } ctrl_t;
endpackage

// File: rtl/tmb_regs.sv
module tmb_regs
  import tmb_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              upd_i,
  output ctrl_t             ctrl_o,
  output logic              ug_o,
  output logic [PSC_W-1:0]  psc_pre_o,
  output logic [CNT_W-1:0]  arr_pre_o,
  output logic              arr_wr_o,
  output logic              flag_clr_o,
  output logic              ien_o
);
  ctrl_t ctrl_q;
  logic  ug_q;
  logic  ctrl_wr;

  assign ctrl_wr    = wr_en_i && (wr_addr_i == A_CTRL);
  assign arr_wr_o   = wr_en_i && (wr_addr_i == A_RELOAD);
  assign flag_clr_o = wr_en_i && (wr_addr_i == A_FLAG) && !wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      ug_q      <= 1'b0;
      psc_pre_o <= '0;
      arr_pre_o <= '1;
      ien_o     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      end else if (upd_i && ctrl_q.oneshot) begin
        ctrl_q.run <= 1'b0;
      end
      // generate request lives for exactly one cycle unless rewritten
      ug_q <= wr_en_i && (wr_addr_i == A_EVENT) && wr_data_i[0];
      if (wr_en_i && (wr_addr_i == A_PSC)) psc_pre_o <= wr_data_i[PSC_W-1:0];
      if (arr_wr_o) arr_pre_o <= wr_data_i;
      if (wr_en_i && (wr_addr_i == A_IEN)) ien_o <= wr_data_i[0];
    end
  end

  assign ctrl_o = ctrl_q;
  assign ug_o   = ug_q;

  a_r7_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && ctrl_q.oneshot && !ctrl_wr) |=> !ctrl_q.run);
endmodule

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
  parameter int unsigned PSC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             udis_i,
  input  logic [PSC_W-1:0] code_pre_i,
  input  logic             upd_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;
  localparam logic [DIV_W:0] ONE = {{DIV_W{1'b0}}, 1'b1};

  logic [PSC_W-1:0] code_act;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  assign lim    = DIV_W'((ONE << code_act) - ONE);
  assign tick_o = run_i && (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_act <= '0;
      div_q    <= '0;
    end else begin
      if (upd_i) code_act <= code_pre_i;
      if (restart_i) begin
        div_q <= '0;
      end else if (run_i) begin
        div_q <= (div_q == lim) ? '0 : div_q + DIV_W'(1);
      end
    end
  end

  a_r3_div_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= lim);
  a_r5_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udis_i |=> $stable(code_act));
endmodule

// File: rtl/tmb_counter.sv
module tmb_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             upd_i,
  input  logic             restart_i,
  input  logic             arr_wr_i,
  input  logic [CNT_W-1:0] arr_data_i,
  input  logic             rpre_i,
  input  logic [CNT_W-1:0] arr_pre_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] arr_act;

  assign ovf_o = tick_i && (cnt_q == arr_act);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_act <= '1;
    end else if (arr_wr_i && !rpre_i) begin
      arr_act <= arr_data_i;
    end else if (upd_i) begin
      arr_act <= arr_pre_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= ovf_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  a_r4_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
  a_r2_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmb_update.sv
module tmb_update (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic ug_i,
  input  logic udis_i,
  input  logic ovf_only_i,
  input  logic flag_clr_i,
  input  logic ien_i,
  output logic upd_o,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;
  logic flag_set;

  assign upd_o    = (ovf_i || ug_i) && !udis_i;
  assign flag_set = upd_o && (ovf_i || !ovf_only_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_set) begin
      flag_q <= 1'b1;
    end else if (flag_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ien_i;

  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q);
  a_r6_sw_source_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && ovf_only_i && !ovf_i) |=> !flag_q);
  a_r5_no_flag_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && udis_i) |=> !flag_q);
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase
  import tmb_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic              upd_pulse_o,
  output logic              upd_flag_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              running_o
);
  ctrl_t            ctrl;
  logic             ug;
  logic [PSC_W-1:0] psc_pre;
  logic [CNT_W-1:0] arr_pre;
  logic             arr_wr;
  logic             flag_clr;
  logic             ien;
  logic             upd;
  logic             restart;
  logic             tick;
  logic             ovf;

  // a software request only restarts the time-base when updates are allowed
  assign restart = ug && !ctrl.udis;

  tmb_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .upd_i(upd), .ctrl_o(ctrl), .ug_o(ug),
    .psc_pre_o(psc_pre), .arr_pre_o(arr_pre), .arr_wr_o(arr_wr),
    .flag_clr_o(flag_clr), .ien_o(ien)
  );

  tmb_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .run_i(ctrl.run), .udis_i(ctrl.udis), .code_pre_i(psc_pre),
    .upd_i(upd), .restart_i(restart), .tick_o(tick)
  );

  tmb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .tick_i(tick), .upd_i(upd), .restart_i(restart),
    .arr_wr_i(arr_wr), .arr_data_i(wr_data_i), .rpre_i(ctrl.rpre),
    .arr_pre_i(arr_pre), .cnt_o(count_o), .ovf_o(ovf)
  );

  tmb_update u_upd (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ovf_i(ovf), .ug_i(ug), .udis_i(ctrl.udis), .ovf_only_i(ctrl.ovf_only),
    .flag_clr_i(flag_clr), .ien_i(ien),
    .upd_o(upd), .flag_o(upd_flag_o), .irq_o(irq_o)
  );

  assign upd_pulse_o = upd;
  assign running_o   = ctrl.run;

  a_r10_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> upd_flag_o);
  a_r7_idle_count_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !restart) |=> $stable(count_o));
endmodule

// File: tb/tick_timebase_tb.sv
module tick_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        upd_pulse, upd_flag, irq, running;
  logic [15:0] count;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  tick_timebase dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .upd_pulse_o(upd_pulse), .upd_flag_o(upd_flag), .irq_o(irq),
    .count_o(count), .running_o(running)
  );

  // vector: {divider code, reload value}; expected period = (reload+1) << code
  localparam logic [19:0] VECS [7] = '{
    {4'd0, 16'd3}, {4'd1, 16'd4}, {4'd2, 16'd2}, {4'd3, 16'd1},
    {4'd4, 16'd5}, {4'd0, 16'd1}, {4'd5, 16'd0}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_to_pulse(output int n);
    n = 0;
    while (!upd_pulse && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure_period(output int n);
    int w;
    count_to_pulse(w);
    @(negedge clk);
    n = 1;
    while (!upd_pulse && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int p, c, seen;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 pulse", upd_pulse, 0);
    chk("R1 flag", upd_flag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 running", running, 0);
    rst_n = 1'b1;
    wr(3'd0, 16'h0001);
    count_to_pulse(p);  // reload still 0xFFFF: no pulse for a long time
    chk("R1 no early wrap", (count > 16'd1000) ? 1 : 0, 1);
    wr(3'd0, 16'h0000);

    // R2/R3: period table
    for (int i = 0; i < 7; i++) begin
      int exp_p;
      exp_p = (int'(VECS[i][15:0]) + 1) << VECS[i][19:16];
      wr(3'd0, 16'h0000);
      wr(3'd3, {12'd0, VECS[i][19:16]});
      wr(3'd4, VECS[i][15:0]);
      wr(3'd1, 16'h0001);
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'h0001);
      measure_period(p);
      chk("R2 R3 period", p, exp_p);
      chk("R6 overflow sets flag", upd_flag, 1);
      @(negedge clk);
      chk("R2 pulse one clock", upd_pulse, 0);
    end

    // R4: software update
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'd10);
    wr(3'd0, 16'h0001);
    repeat (5) @(negedge clk);
    wr(3'd2, 16'h0000);
    wr(3'd1, 16'h0001);
    chk("R4 pulse after event write", upd_pulse, 1);
    @(negedge clk);
    chk("R4 counter cleared", count, 0);
    chk("R4 single pulse", upd_pulse, 0);
    chk("R6 software sets flag when source open", upd_flag, 1);
    @(negedge clk);
    chk("R4 divider restarted with new code", count, 1);

    // R3: code change deferred
    wr(3'd4, 16'd20);
    wr(3'd3, 16'd3);
    c = count;
    @(negedge clk);
    chk("R3 old rate kept until update", count, c + 1);
    wr(3'd1, 16'h0001);
    measure_period(p);
    chk("R3 new rate after update", p, 168);

    // R5: update suppress
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0001);
    chk("R5 no pulse on event write", upd_pulse, 0);
    c = count;
    repeat (8) @(negedge clk);
    chk("R5 old divider kept, no restart", count, (c == 20) ? 0 : c + 1);
    seen = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (upd_pulse) seen++;
    end
    chk("R5 no pulse on overflow", seen, 0);
    chk("R5 flag untouched", upd_flag, 0);

    // R6: overflow-only source
    wr(3'd0, 16'h0004);
    wr(3'd1, 16'h0001);
    chk("R6 event still pulses", upd_pulse, 1);
    @(negedge clk);
    chk("R6 software blocked from flag", upd_flag, 0);
    wr(3'd0, 16'h0005);
    count_to_pulse(p);
    @(negedge clk);
    chk("R6 overflow sets flag", upd_flag, 1);

    // R9/R10: flag and interrupt
    wr(3'd0, 16'h0000);
    chk("R10 irq masked", irq, 0);
    wr(3'd5, 16'h0001);
    chk("R10 irq enabled", irq, 1);
    chk("R10 flag unchanged by enable", upd_flag, 1);
    wr(3'd2, 16'h0001);
    chk("R9 writing 1 keeps flag", upd_flag, 1);
    wr(3'd2, 16'h0000);
    chk("R9 writing 0 clears flag", upd_flag, 0);
    chk("R10 irq follows flag", irq, 0);
    wr(3'd5, 16'h0000);

    // R7: single period
    wr(3'd4, 16'd20);
    wr(3'd1, 16'h0001);
    wr(3'd0, 16'h0009);
    count_to_pulse(p);
    chk("R7 period before stop", p, 20);
    @(negedge clk);
    chk("R7 running dropped", running, 0);
    chk("R7 counter at zero", count, 0);
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (upd_pulse) seen++;
    end
    chk("R7 no further pulse", seen, 0);
    chk("R7 counter stays zero", count, 0);

    // R8: buffered reload
    wr(3'd0, 16'h0011);
    wr(3'd1, 16'h0001);
    wr(3'd4, 16'd5);
    count_to_pulse(p);
    chk("R8 buffered write waits for update", p, 19);
    measure_period(p);
    chk("R8 buffered value after update", p, 6);
    // R8: direct reload
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'd20);
    wr(3'd1, 16'h0001);
    wr(3'd4, 16'd5);
    count_to_pulse(p);
    chk("R8 direct write immediate", p, 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule